// File: doc/BRIEF.md
# Serial Audio Stereo Receiver with Buffer Watermarks

This block takes a slave-mode serial audio stream (bit clock, frame clock and one data line, all asynchronous to the system clock) and turns it into 32-bit words in a 32-entry receive buffer. It captures one left and one right sample per frame in three two-channel framings (standard, left-aligned, right-aligned) or in four pulse-synchronised framings whose first data bit follows the sync pulse by zero to three bit clocks. Bit order, sample width (16 to 32 bits), the way samples are placed in a word, and the polarities of both clocks are set by a configuration bundle. The bundle is expected to be static while data flows.

A CPU or DMA engine drains the buffer through a read port with show-ahead data. The fill level drives a DMA request and a fill-threshold interrupt. A sample that arrives when the buffer is full is thrown away and raises a sticky overrun flag. A self-clearing clear input empties the buffer and makes the deserializer wait for a fresh frame start.

Top module: `audio_rx_top`

## Requirements
- R1: The buffer holds 32 words of 32 bits. `level` counts stored words from 0 to 32. `rd_data` shows the oldest word, and `rd_en` removes it. A read while `level` is 0 has no effect.
- R2: `dma_req` is high exactly when `dma_en` is 1 and `level` is greater than or equal to `dma_lvl` + 1.
- R3: `irq_full` is high exactly when `full_ie` is 1 and `level` is greater than or equal to `full_thr` + 1.
- R4: A word produced while `level` is 32 is dropped. The stored words and the level stay as they were, and a sticky overrun flag is set. `irq_ovr` is the flag ANDed with `ovr_ie`. A one-cycle pulse on `ovr_clr` clears the flag.
- R5: Standard framing (`cfg_pcm`=0, `cfg_i2s_mode`=0): frame clock 0 marks left and 1 marks right. The first data bit of a channel comes one bit clock after the frame clock changes.
- R6: Left-aligned framing (`cfg_i2s_mode`=1): frame clock 1 marks left. The first data bit is sampled at the same bit clock as the frame clock change.
- R7: Right-aligned framing (`cfg_i2s_mode`=2): frame clock 1 marks left. The last data bit of a channel is the last bit before the frame clock changes.
- R8: Pulse framing (`cfg_pcm`=1): a rising sync starts a frame. The left sample begins `cfg_pcm_dly` (0 to 3) bit clocks after the sync bit and the right sample follows at once. Bits outside these two samples are ignored.
- R9: `cfg_lsb_first`=0 takes the first bit received as the sample MSB. `cfg_lsb_first`=1 takes it as the LSB.
- R10: `cfg_width` codes 15 to 31 select sample widths of 16 to 32 bits.
- R11: With `cfg_pack16`=1 and `cfg_width`=15, left goes to bits 15:0 and right to bits 31:16 of a single word. Otherwise each sample is its own word, low-aligned when `cfg_just_high`=0 and high-aligned with zero fill below when it is 1. Left is stored before right.
- R12: `cfg_fclk_inv`=1 swaps the channel meaning in the two-channel framings and makes the sync active low in pulse framing. `cfg_bclk_inv`=0 samples on rising bit clock edges and 1 on falling edges.
- R13: A one-cycle pulse on `soft_clr` empties the buffer and resets the deserializer, which then waits for a new frame clock change or sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Serial bit clock (asynchronous) |
| fclk_i | input | 1 | Frame clock or sync (asynchronous) |
| sdata_i | input | 1 | Serial data |
| cfg_pcm | input | 1 | 1 selects pulse framing |
| cfg_i2s_mode | input | 2 | 0 standard, 1 left-aligned, 2 right-aligned |
| cfg_pcm_dly | input | 2 | Sync to first bit delay in bit clocks |
| cfg_lsb_first | input | 1 | Bit order |
| cfg_width | input | 5 | Sample width minus one (15 to 31) |
| cfg_pack16 | input | 1 | Pack two 16-bit samples into one word |
| cfg_just_high | input | 1 | High-align unpacked samples |
| cfg_fclk_inv | input | 1 | Frame clock polarity |
| cfg_bclk_inv | input | 1 | Bit clock sampling edge |
| dma_en | input | 1 | DMA request enable |
| dma_lvl | input | 5 | DMA level setting |
| full_ie | input | 1 | Fill interrupt enable |
| full_thr | input | 5 | Fill interrupt threshold |
| ovr_ie | input | 1 | Overrun interrupt enable |
| ovr_clr | input | 1 | Overrun flag clear pulse |
| soft_clr | input | 1 | Buffer and deserializer clear pulse |
| rd_en | input | 1 | Pop the oldest word |
| rd_data | output | 32 | Oldest stored word |
| level | output | 6 | Number of stored words |
| dma_req | output | 1 | DMA request |
| irq_full | output | 1 | Fill-threshold interrupt |
| irq_ovr | output | 1 | Overrun interrupt |

## Verification
The bench builds the block with its default parameters: a depth of 32, a two-stage input synchronizer and an 8-bit bit counter. At that size the whole buffer can be filled, overrun and drained, and both watermarks are swept over all 32 settings at every fill level from 0 to 32. Every framing is run at several sample widths under each bit order and each storage option, every width code is run in two framings, and every clock polarity combination is run in every framing. Each expected word is computed in the bench from the sample values that were sent.

// File: rtl/audio_rx_pkg.sv
package audio_rx_pkg;

  localparam int WORD_W = 32;
  localparam int WSEL_W = 6;

  localparam logic [1:0] FR_STD   = 2'd0;
  localparam logic [1:0] FR_LEFT  = 2'd1;
  localparam logic [1:0] FR_RIGHT = 2'd2;

  typedef struct packed {
    logic       pcm;
    logic [1:0] i2s_mode;
    logic [1:0] pcm_dly;
    logic       lsb_first;
    logic [4:0] width;
    logic       pack16;
    logic       just_high;
    logic       fclk_inv;
    logic       bclk_inv;
  } rx_cfg_t;

  // Turn a shifted-in raw window into a low-aligned sample of w bits.
  function automatic logic [WORD_W-1:0] orient_sample(
    input logic [WORD_W-1:0] raw,
    input logic [WSEL_W-1:0] w,
    input logic              lsb
  );
    logic [WORD_W-1:0] m;
    logic [WORD_W-1:0] r;
    m = (w >= WSEL_W'(WORD_W)) ? '1 : ((WORD_W'(1) << w) - WORD_W'(1));
    for (int i = 0; i < WORD_W; i++) r[i] = raw[WORD_W-1-i];
    return lsb ? (r >> (WSEL_W'(WORD_W) - w)) : (raw & m);
  endfunction

endpackage

// File: rtl/audio_rx_sync.sv
module audio_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_i,
  input  logic fclk_i,
  input  logic sdata_i,
  input  logic bclk_inv,
  output logic bit_ev,
  output logic fclk_s,
  output logic sdata_s
);

  logic [2:0] stage_q [STAGES];
  logic       bclk_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= {bclk_i, fclk_i, sdata_i};
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= '0;
      else        stage_q[g] <= stage_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bclk_prev_q <= 1'b0;
    else        bclk_prev_q <= stage_q[STAGES-1][2];
  end

  assign bit_ev  = (stage_q[STAGES-1][2] != bclk_prev_q) && (stage_q[STAGES-1][2] == ~bclk_inv);
  assign fclk_s  = stage_q[STAGES-1][1];
  assign sdata_s = stage_q[STAGES-1][0];

endmodule

// File: rtl/audio_rx_deser.sv
module audio_rx_deser
  import audio_rx_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              bit_ev,
  input  logic              fclk_s,
  input  logic              sdata_s,
  input  rx_cfg_t           cfg,
  output logic              commit_o,
  output logic              commit_left_o,
  output logic [WORD_W-1:0] commit_val_o
);

  logic              lr_d1_q, lr_d1_n, lr_d2_q, lr_d2_n;
  logic [1:0]        hist_q, hist_n;
  logic              synced_q, synced_n, pact_q, pact_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [WORD_W-1:0] sr_q, sr_n, sr_sh, raw;
  logic              cm_q, cm_n, cml_q, cml_n;
  logic [WORD_W-1:0] cmv_q, cmv_n;

  logic              lr, is_std, is_rj, eff, effp, chg, start, edge_ev, take, left_sel;
  logic [WSEL_W-1:0] w;
  logic [CNT_W-1:0]  idx, rel;

  assign lr     = fclk_s ^ cfg.fclk_inv;
  assign w      = WSEL_W'(cfg.width) + WSEL_W'(1);
  assign is_std = (cfg.i2s_mode == FR_STD);
  assign is_rj  = (cfg.i2s_mode == FR_RIGHT);
  // Standard framing is left-aligned framing seen through a one-bit-late frame clock.
  assign eff    = is_std ? lr_d1_q : lr;
  assign effp   = is_std ? lr_d2_q : lr_d1_q;
  assign chg    = !cfg.pcm && (hist_q >= (is_std ? 2'd2 : 2'd1)) && (eff != effp);
  assign start  = cfg.pcm && (hist_q != 2'd0) && lr && !lr_d1_q;
  assign edge_ev = cfg.pcm ? start : chg;
  assign idx    = edge_ev ? '0 : cnt_q;
  assign rel    = idx - CNT_W'(cfg.pcm_dly);
  assign sr_sh  = {sr_q[WORD_W-2:0], sdata_s};

  always_comb begin
    lr_d1_n  = lr_d1_q;
    lr_d2_n  = lr_d2_q;
    hist_n   = hist_q;
    synced_n = synced_q;
    pact_n   = pact_q;
    cnt_n    = cnt_q;
    sr_n     = sr_q;
    take     = 1'b0;
    left_sel = 1'b0;
    raw      = sr_q;
    if (bit_ev) begin
      lr_d1_n = lr;
      lr_d2_n = lr_d1_q;
      hist_n  = (hist_q == 2'd2) ? hist_q : hist_q + 2'd1;
      cnt_n   = (&idx) ? idx : idx + CNT_W'(1);
      if (edge_ev) synced_n = 1'b1;
      if (cfg.pcm) begin
        if (start) pact_n = 1'b1;
        if ((start || pact_q) && (idx >= CNT_W'(cfg.pcm_dly)) && (rel < CNT_W'({w, 1'b0}))) begin
          sr_n = sr_sh;
          if (rel == CNT_W'(w) - CNT_W'(1)) begin
            take = 1'b1; raw = sr_sh; left_sel = 1'b1;
          end
          if (rel == CNT_W'({w, 1'b0}) - CNT_W'(1)) begin
            take = 1'b1; raw = sr_sh; left_sel = 1'b0; pact_n = 1'b0;
          end
        end
      end else if (is_rj) begin
        sr_n = sr_sh;
        if (chg && synced_q) begin
          take = 1'b1; raw = sr_q; left_sel = lr_d1_q;
        end
      end else if ((synced_q || chg) && (idx < CNT_W'(w))) begin
        sr_n = sr_sh;
        if (idx == CNT_W'(w) - CNT_W'(1)) begin
          take = 1'b1; raw = sr_sh; left_sel = is_std ? ~eff : eff;
        end
      end
    end
    cm_n  = take;
    cml_n = take ? left_sel : cml_q;
    cmv_n = take ? orient_sample(raw, w, cfg.lsb_first) : cmv_q;
    if (clr) begin
      lr_d1_n = 1'b0; lr_d2_n = 1'b0; hist_n = '0; synced_n = 1'b0;
      pact_n = 1'b0; cnt_n = '0; sr_n = '0; cm_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lr_d1_q <= 1'b0; lr_d2_q <= 1'b0; hist_q <= '0; synced_q <= 1'b0;
      pact_q <= 1'b0; cnt_q <= '0; sr_q <= '0;
      cm_q <= 1'b0; cml_q <= 1'b0; cmv_q <= '0;
    end else begin
      lr_d1_q <= lr_d1_n; lr_d2_q <= lr_d2_n; hist_q <= hist_n; synced_q <= synced_n;
      pact_q <= pact_n; cnt_q <= cnt_n; sr_q <= sr_n;
      cm_q <= cm_n; cml_q <= cml_n; cmv_q <= cmv_n;
    end
  end

  assign commit_o      = cm_q;
  assign commit_left_o = cml_q;
  assign commit_val_o  = cmv_q;

  AST_CLR_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr) |-> !commit_o); // R13

endmodule

// File: rtl/audio_rx_packer.sv
module audio_rx_packer
  import audio_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              commit,
  input  logic              commit_left,
  input  logic [WORD_W-1:0] commit_val,
  input  rx_cfg_t           cfg,
  output logic              wr,
  output logic [WORD_W-1:0] wdata
);

  logic [15:0]       hold_q, hold_n;
  logic              pack_on;
  logic [WSEL_W-1:0] w;

  assign w       = WSEL_W'(cfg.width) + WSEL_W'(1);
  assign pack_on = cfg.pack16 && (cfg.width == 5'd15);

  always_comb begin
    hold_n = hold_q;
    if (commit && pack_on && commit_left) hold_n = commit_val[15:0];
    if (clr) hold_n = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_n;
  end

  always_comb begin
    wr = commit && !clr && (!pack_on || !commit_left);
    if (pack_on)            wdata = {commit_val[15:0], hold_q};
    else if (cfg.just_high) wdata = commit_val << (WSEL_W'(WORD_W) - w);
    else                    wdata = commit_val;
  end

  AST_PACK_ONE_PER_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && pack_on) |-> !commit_left); // R11

endmodule

// File: rtl/audio_rx_fifo.sv
module audio_rx_fifo #(
  parameter int DEPTH  = 32,
  parameter int WIDTH  = 32,
  localparam int AW    = $clog2(DEPTH),
  localparam int LW    = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             rd,
  output logic [WIDTH-1:0] rdata,
  output logic [LW-1:0]    level,
  output logic             full,
  output logic             drop
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp_q, wp_n, rp_q, rp_n;
  logic [LW-1:0]    lvl_q, lvl_n;
  logic             push, pop;

  assign full = (lvl_q == LW'(DEPTH));
  assign push = wr && !full && !clr;
  assign pop  = rd && (lvl_q != '0) && !clr;
  assign drop = wr && full && !clr;

  always_comb begin
    wp_n  = push ? wp_q + AW'(1) : wp_q;
    rp_n  = pop  ? rp_q + AW'(1) : rp_q;
    lvl_n = lvl_q + LW'(push) - LW'(pop);
    if (clr) begin
      wp_n = '0; rp_n = '0; lvl_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0; rp_q <= '0; lvl_q <= '0;
    end else begin
      wp_q <= wp_n; rp_q <= rp_n; lvl_q <= lvl_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= wdata;
  end

  assign rdata = mem[rp_q];
  assign level = lvl_q;

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH)); // R1
  AST_EMPTY_READ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0 && rd && !wr && !clr) |=> (level == '0)); // R1
  AST_FULL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr && !rd && !clr) |=> (level == LW'(DEPTH))); // R4

endmodule

// File: rtl/audio_rx_top.sv
module audio_rx_top
  import audio_rx_pkg::*;
#(
  parameter int DEPTH       = 32,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 8,
  localparam int AW         = $clog2(DEPTH),
  localparam int LW         = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_i,
  input  logic              fclk_i,
  input  logic              sdata_i,
  input  logic              cfg_pcm,
  input  logic [1:0]        cfg_i2s_mode,
  input  logic [1:0]        cfg_pcm_dly,
  input  logic              cfg_lsb_first,
  input  logic [4:0]        cfg_width,
  input  logic              cfg_pack16,
  input  logic              cfg_just_high,
  input  logic              cfg_fclk_inv,
  input  logic              cfg_bclk_inv,
  input  logic              dma_en,
  input  logic [AW-1:0]     dma_lvl,
  input  logic              full_ie,
  input  logic [AW-1:0]     full_thr,
  input  logic              ovr_ie,
  input  logic              ovr_clr,
  input  logic              soft_clr,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_data,
  output logic [LW-1:0]     level,
  output logic              dma_req,
  output logic              irq_full,
  output logic              irq_ovr
);

  logic [1:0]        rst_sq;
  logic              rst_ns;
  rx_cfg_t           cfg;
  logic              bit_ev, fclk_s, sdata_s;
  logic              cm, cm_left;
  logic [WORD_W-1:0] cm_val, wdata;
  logic              wr, fifo_full, drop;
  logic              ovr_q, ovr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sq <= '0;
    else        rst_sq <= {rst_sq[0], 1'b1};
  end
  assign rst_ns = rst_sq[1];

  assign cfg = '{pcm: cfg_pcm, i2s_mode: cfg_i2s_mode, pcm_dly: cfg_pcm_dly,
                 lsb_first: cfg_lsb_first, width: cfg_width, pack16: cfg_pack16,
                 just_high: cfg_just_high, fclk_inv: cfg_fclk_inv, bclk_inv: cfg_bclk_inv};

  audio_rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_ns), .bclk_i(bclk_i), .fclk_i(fclk_i), .sdata_i(sdata_i),
    .bclk_inv(cfg_bclk_inv), .bit_ev(bit_ev), .fclk_s(fclk_s), .sdata_s(sdata_s));

  audio_rx_deser #(.CNT_W(CNT_W)) i_deser (
    .clk(clk), .rst_n(rst_ns), .clr(soft_clr), .bit_ev(bit_ev), .fclk_s(fclk_s),
    .sdata_s(sdata_s), .cfg(cfg), .commit_o(cm), .commit_left_o(cm_left),
    .commit_val_o(cm_val));

  audio_rx_packer i_packer (
    .clk(clk), .rst_n(rst_ns), .clr(soft_clr), .commit(cm), .commit_left(cm_left),
    .commit_val(cm_val), .cfg(cfg), .wr(wr), .wdata(wdata));

  audio_rx_fifo #(.DEPTH(DEPTH), .WIDTH(WORD_W)) i_fifo (
    .clk(clk), .rst_n(rst_ns), .clr(soft_clr), .wr(wr), .wdata(wdata), .rd(rd_en),
    .rdata(rd_data), .level(level), .full(fifo_full), .drop(drop));

  always_comb begin
    ovr_n = ovr_q;
    if (ovr_clr) ovr_n = 1'b0;
    if (drop)    ovr_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) ovr_q <= 1'b0;
    else         ovr_q <= ovr_n;
  end

  assign dma_req  = dma_en  && (level >= LW'(dma_lvl) + LW'(1));
  assign irq_full = full_ie && (level >= LW'(full_thr) + LW'(1));
  assign irq_ovr  = ovr_ie  && ovr_q;

  AST_DMA_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_ns)
    dma_req |-> (level != '0)); // R2
  AST_FULL_IRQ_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_ns)
    irq_full |-> (level != '0)); // R3
  AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(ovr_q) |-> $past(fifo_full)); // R4

endmodule

// File: tb/test_audio_rx_top.sv
`timescale 1ns/1ps
module test_audio_rx_top;

  logic clk = 1'b0;
  logic rst_n;
  logic bclk_i, fclk_i, sdata_i;
  logic cfg_pcm, cfg_lsb_first, cfg_pack16, cfg_just_high, cfg_fclk_inv, cfg_bclk_inv;
  logic [1:0] cfg_i2s_mode, cfg_pcm_dly;
  logic [4:0] cfg_width, dma_lvl, full_thr;
  logic dma_en, full_ie, ovr_ie, ovr_clr, soft_clr, rd_en;
  logic [31:0] rd_data;
  logic [5:0] level;
  logic dma_req, irq_full, irq_ovr;

  int nv = 0;
  int nf = 0;
  logic [31:0] stash [32];

  always #2.5 clk = ~clk;

  audio_rx_top i_audio_rx_top (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk_i), .fclk_i(fclk_i), .sdata_i(sdata_i),
    .cfg_pcm(cfg_pcm), .cfg_i2s_mode(cfg_i2s_mode), .cfg_pcm_dly(cfg_pcm_dly),
    .cfg_lsb_first(cfg_lsb_first), .cfg_width(cfg_width), .cfg_pack16(cfg_pack16),
    .cfg_just_high(cfg_just_high), .cfg_fclk_inv(cfg_fclk_inv), .cfg_bclk_inv(cfg_bclk_inv),
    .dma_en(dma_en), .dma_lvl(dma_lvl), .full_ie(full_ie), .full_thr(full_thr),
    .ovr_ie(ovr_ie), .ovr_clr(ovr_clr), .soft_clr(soft_clr), .rd_en(rd_en),
    .rd_data(rd_data), .level(level), .dma_req(dma_req), .irq_full(irq_full),
    .irq_ovr(irq_ovr));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nv++;
    if (act !== exp) begin
      nf++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] msk(input int w);
    return (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
  endfunction

  // mode: 0 standard, 1 left-aligned, 2 right-aligned, 3..6 pulse with delay mode-3
  function automatic logic sd_at(input int mode, input int w, input bit lsb, input int p,
                                 input logic [31:0] l, input logic [31:0] r);
    for (int c = 0; c < 2; c++) begin
      int k;
      logic [31:0] v;
      if (mode >= 3) k = p - (mode - 3) - c * w;
      else k = p - c * 32 - ((mode == 0) ? 1 : (mode == 1) ? 0 : 32 - w);
      v = (c == 1) ? r : l;
      if (k >= 0 && k < w) return v[lsb ? k : w - 1 - k];
    end
    return ((p & 3) == 1);
  endfunction

  function automatic logic lr_at(input int mode, input int p);
    if (mode >= 3) return (p == 0) ^ cfg_fclk_inv;
    begin
      bit left;
      logic lv;
      left = (p >= 0 && p < 32) || p >= 64;
      lv = (mode == 0) ? 1'b0 : 1'b1;
      return (left ? lv : ~lv) ^ cfg_fclk_inv;
    end
  endfunction

  task automatic set_mode(input int mode, input int w, input bit lsb);
    cfg_pcm       = (mode >= 3);
    cfg_i2s_mode  = (mode >= 3) ? 2'd0 : 2'(mode);
    cfg_pcm_dly   = (mode >= 3) ? 2'(mode - 3) : 2'd0;
    cfg_width     = 5'(w - 1);
    cfg_lsb_first = lsb;
    bclk_i        = cfg_bclk_inv;
  endtask

  task automatic pulse_clr();
    soft_clr = 1'b1; tick(1); soft_clr = 1'b0; tick(1);
  endtask

  task automatic send(input int mode, input int w, input bit lsb,
                      input logic [31:0] l, input logic [31:0] r, input int stop_p);
    int last;
    last = (mode >= 3) ? 2 * w + (mode - 3) + 3 : 67;
    if (stop_p >= 0) last = stop_p;
    for (int p = -2; p <= last; p++) begin
      bclk_i = cfg_bclk_inv;
      fclk_i = lr_at(mode, p);
      sdata_i = sd_at(mode, w, lsb, p, l, r);
      tick(2);
      bclk_i = ~cfg_bclk_inv;
      tick(2);
    end
    bclk_i = cfg_bclk_inv;
    tick(12);
  endtask

  task automatic pop_chk(input string req, input logic [31:0] exp);
    chk(req, rd_data, exp);
    rd_en = 1'b1; tick(1); rd_en = 1'b0;
  endtask

  task automatic frame_chk(input int mode, input int w, input bit lsb, input int jm,
                           input int seed, input string req);
    logic [31:0] l, r, e0, e1;
    bit packed16;
    l = (32'(seed) * 32'h9E37_79B1 + 32'h1234_5678) & msk(w);
    r = (32'(seed) * 32'h85EB_CA6B + 32'h0BAD_F00D) & msk(w);
    cfg_pack16 = (jm == 2);
    cfg_just_high = (jm == 1);
    set_mode(mode, w, lsb);
    pulse_clr();
    send(mode, w, lsb, l, r, -1);
    packed16 = (jm == 2) && (w == 16);
    e0 = (jm == 1) ? (l << (32 - w)) : l;
    e1 = (jm == 1) ? (r << (32 - w)) : r;
    if (packed16) begin
      chk({req, " R11 pack level"}, 32'(level), 32'd1);
      pop_chk({req, " R11 packed word"}, {r[15:0], l[15:0]});
    end else begin
      chk({req, " R1 level"}, 32'(level), 32'd2);
      pop_chk({req, " R9 R11 left word"}, e0);
      pop_chk({req, " R9 R11 right word"}, e1);
    end
  endtask

  task automatic thr_sweep(input int lvl);
    for (int s = 0; s < 32; s++) begin
      dma_lvl = 5'(s);
      full_thr = 5'(31 - s);
      tick(1);
      chk("R2 dma request", 32'(dma_req), 32'(lvl >= s + 1));
      chk("R3 full interrupt", 32'(irq_full), 32'(lvl >= 32 - s));
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nf++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nv, nf);
    $finish;
  end

  initial begin
    int seed;
    int ws [3];
    ws = '{16, 24, 32};
    seed = 1;
    rst_n = 1'b0;
    bclk_i = 1'b0; fclk_i = 1'b0; sdata_i = 1'b0;
    cfg_pcm = 1'b0; cfg_i2s_mode = 2'd1; cfg_pcm_dly = 2'd0; cfg_lsb_first = 1'b0;
    cfg_width = 5'd31; cfg_pack16 = 1'b0; cfg_just_high = 1'b0;
    cfg_fclk_inv = 1'b0; cfg_bclk_inv = 1'b0;
    dma_en = 1'b1; dma_lvl = 5'd0; full_ie = 1'b1; full_thr = 5'd0;
    ovr_ie = 1'b1; ovr_clr = 1'b0; soft_clr = 1'b0; rd_en = 1'b0;
    tick(4);
    rst_n = 1'b1;
    tick(4);
    chk("R1 reset level", 32'(level), 32'd0);
    chk("R2 reset dma", 32'(dma_req), 32'd0);
    chk("R3 reset full irq", 32'(irq_full), 32'd0);
    chk("R4 reset overrun", 32'(irq_ovr), 32'd0);

    // Sweep A: every framing, three widths, both bit orders, three storage options.
    for (int m = 0; m < 7; m++)
      for (int wi = 0; wi < 3; wi++)
        for (int b = 0; b < 2; b++)
          for (int jm = 0; jm < 3; jm++) begin
            string t;
            t = (m == 0) ? "R5" : (m == 1) ? "R6" : (m == 2) ? "R7" : "R8";
            frame_chk(m, ws[wi], b[0], jm, seed++, t);
          end

    // Sweep B: every width code in right-aligned and pulse framing.
    for (int w = 16; w <= 32; w++) begin
      frame_chk(2, w, w[0], w % 3, seed++, "R10 R7");
      frame_chk(5, w, ~w[0], w % 3, seed++, "R10 R8");
    end

    // Sweep C: clock polarities in every framing.
    for (int pc = 1; pc < 4; pc++) begin
      cfg_fclk_inv = pc[0];
      cfg_bclk_inv = pc[1];
      bclk_i = cfg_bclk_inv;
      tick(4);
      for (int m = 0; m < 7; m++) frame_chk(m, 24, m[0], 0, seed++, "R12");
    end
    cfg_fclk_inv = 1'b0; cfg_bclk_inv = 1'b0; bclk_i = 1'b0;
    tick(4);

    // Clear in the middle of a frame.
    cfg_pack16 = 1'b0; cfg_just_high = 1'b0;
    set_mode(1, 32, 1'b0);
    pulse_clr();
    send(1, 32, 1'b0, 32'hAAAA_5555, 32'h1357_9BDF, 47);
    chk("R13 level before clear", 32'(level), 32'd1);
    pulse_clr();
    chk("R13 level after clear", 32'(level), 32'd0);
    send(1, 32, 1'b0, 32'hCAFE_0001, 32'hBEEF_0002, -1);
    chk("R13 level after fresh frame", 32'(level), 32'd2);
    pop_chk("R13 left after clear", 32'hCAFE_0001);
    pop_chk("R13 right after clear", 32'hBEEF_0002);

    // Fill, overrun, drain with watermark sweeps.
    pulse_clr();
    for (int f = 0; f < 16; f++) begin
      stash[2*f]   = 32'(f) * 32'h0101_0101 + 32'hA000_0000;
      stash[2*f+1] = 32'(f) * 32'h0202_0202 + 32'h5000_0000;
      send(1, 32, 1'b0, stash[2*f], stash[2*f+1], -1);
      chk("R1 fill level", 32'(level), 32'(2 * f + 2));
    end
    chk("R4 no overrun yet", 32'(irq_ovr), 32'd0);
    send(1, 32, 1'b0, 32'hDEAD_DEAD, 32'hFEED_FEED, -1);
    chk("R4 level held at full", 32'(level), 32'd32);
    chk("R4 overrun raised", 32'(irq_ovr), 32'd1);
    ovr_ie = 1'b0; tick(1);
    chk("R4 overrun masked", 32'(irq_ovr), 32'd0);
    ovr_ie = 1'b1; tick(1);
    dma_en = 1'b0; dma_lvl = 5'd0; tick(1);
    chk("R2 dma disabled", 32'(dma_req), 32'd0);
    full_ie = 1'b0; full_thr = 5'd0; tick(1);
    chk("R3 full irq disabled", 32'(irq_full), 32'd0);
    dma_en = 1'b1; full_ie = 1'b1;
    for (int k = 0; k < 32; k++) begin
      thr_sweep(32 - k);
      pop_chk("R4 R1 stored word kept", stash[k]);
    end
    thr_sweep(0);
    rd_en = 1'b1; tick(1); rd_en = 1'b0; tick(1);
    chk("R1 empty read ignored", 32'(level), 32'd0);
    chk("R4 overrun still set", 32'(irq_ovr), 32'd1);
    ovr_clr = 1'b1; tick(1); ovr_clr = 1'b0; tick(1);
    chk("R4 overrun cleared", 32'(irq_ovr), 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", nv, nf);
    $finish;
  end

endmodule